// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a four-beat burst into a synchronous memory. When a burst starts, the block registers the full address from the requester. It then moves the two lowest address bits through a four-step sequence, one step for each cycle in which the active-low advance input is asserted. The upper address bits are not touched for the whole burst.

Two step orders are available, and the mode input picks one when the burst is loaded. The interleaved order combines the start address with a running beat count by XOR. The linear order adds the beat count to the start address and wraps modulo 4. If advance is held deasserted, the current address stays put, which suspends the burst. A new load always wins over advance. A load restarts the beat count at zero.

The block holds only the captured address, the captured mode and the beat count. Its outputs come straight from those registers, so they are valid for the whole cycle after each clock edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_i` is high at a rising edge, the state is cleared. After that edge `addr_o` reads 0 and the captured order is interleaved.
- R2: When `load_i` is high at a rising edge, `addr_o` equals `load_addr_i` sampled at that edge from the next cycle on. This first beat uses beat count 0.
- R3: Bits `addr_o[ADDR_W-1:2]` change only on a load or a reset. Advance and hold cycles leave them equal to the loaded value.
- R4: When `mode_i` is 1 at the load, the order is interleaved and beat k gives low bits equal to start XOR k. Starts 00/01/10/11 give 00,01,10,11 / 01,00,11,10 / 10,11,00,01 / 11,10,01,00.
- R5: When `mode_i` is 0 at the load, the order is linear and beat k gives low bits equal to (start + k) mod 4. For example, start 01 gives 01,10,11,00.
- R6: Each rising edge with `adv_n_i` low and `load_i` low moves to the next beat. After the fourth beat the sequence wraps back to beat 0, which is the start address.
- R7: A rising edge with `adv_n_i` high and `load_i` low leaves `addr_o` unchanged. This suspends the burst.
- R8: When `load_i` and a low `adv_n_i` arrive at the same edge, the load wins. `addr_o` becomes the new load address at beat 0.
- R9: The order is taken from `mode_i` only at a load. Changes on `mode_i` at other edges have no effect on `addr_o`.
- R10: `low_o` always equals `addr_o[1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Start-of-burst strobe, active high |
| load_addr_i | input | ADDR_W | Start address of the burst |
| adv_n_i | input | 1 | Advance to the next beat, active low |
| mode_i | input | 1 | Order select at load: 1 interleaved, 0 linear |
| addr_o | output | ADDR_W | Current full burst address |
| low_o | output | 2 | Generated low address bits |

## Verification
The checker runs on every cycle and covers the following:
- a load shows up as the captured address one cycle later;
- the upper bits stay stable when there is no load;
- a hold cycle freezes the address and an advance cycle always changes the low bits;
- in the linear order each advance adds one modulo 4;
- `low_o` matches the low slice of `addr_o`.

Some properties depend on a whole sequence and only the bench scenarios can show them. These are the exact interleaved patterns for every start value, the wrap back to the start after four advances, a mode change in the middle of a burst having no effect, and load winning over advance. The bench sweeps all four start values in both orders, with holds placed between beats.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // Burst order, captured together with the start address.
    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } order_e;

    // Order used after reset.
    localparam order_e RESET_ORDER = ORDER_INTERLEAVED;

endpackage

// File: rtl/burst_beat_ctr.sv
// Beat counter: clears on load, steps on advance, wraps naturally.
module burst_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic              step_i,
    output logic [BEAT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [BEAT_W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d.cnt = '0;
        end else if (step_i) begin
            state_d.cnt = state_q.cnt + BEAT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_o = state_q.cnt;

endmodule

// File: rtl/burst_addr_capture.sv
// Start-address and order register, written only by a load.
module burst_addr_capture
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BEAT_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              mode_i,
    output logic [ADDR_W-1:0] start_o,
    output order_e            order_o
);

    localparam int UPPER_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [UPPER_W-1:0] upper;
        logic [BEAT_W-1:0]  start;
        order_e             order;
    } cap_state_t;

    cap_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d.upper = load_addr_i[ADDR_W-1:BEAT_W];
            state_d.start = load_addr_i[BEAT_W-1:0];
            state_d.order = mode_i ? ORDER_INTERLEAVED : ORDER_LINEAR;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q.upper <= '0;
            state_q.start <= '0;
            state_q.order <= RESET_ORDER;
        end else begin
            state_q <= state_d;
        end
    end

    assign start_o = {state_q.upper, state_q.start};
    assign order_o = state_q.order;

endmodule

// File: rtl/burst_order_map.sv
// Maps start address and beat count to the current low address bits.
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start_i,
    input  logic [BEAT_W-1:0] cnt_i,
    input  order_e            order_i,
    output logic [BEAT_W-1:0] low_o
);

    logic [BEAT_W-1:0] ilv_low;
    logic [BEAT_W-1:0] lin_low;

    // Interleaved order: each bit flips independently with the count bit.
    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv_bit
        assign ilv_low[b] = start_i[b] ^ cnt_i[b];
    end

    // Linear order: modulo-2^BEAT_W add, carry out dropped.
    assign lin_low = start_i + cnt_i;

    always_comb begin
        unique case (order_i)
            ORDER_INTERLEAVED: low_o = ilv_low;
            ORDER_LINEAR:      low_o = lin_low;
            default:           low_o = ilv_low;
        endcase
    end

endmodule

// File: rtl/burst_addr_seq.sv
// Top: four-beat burst address sequencer.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              adv_n_i,
    input  logic              mode_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        low_o
);

    localparam int BEAT_W = 2;

    logic [ADDR_W-1:0] start_q;
    order_e            order_q;
    logic [BEAT_W-1:0] cnt_q;
    logic [BEAT_W-1:0] low_w;
    logic              step_w;

    assign step_w = ~adv_n_i;

    burst_addr_capture #(
        .ADDR_W(ADDR_W),
        .BEAT_W(BEAT_W)
    ) i_capture (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (load_i),
        .load_addr_i(load_addr_i),
        .mode_i     (mode_i),
        .start_o    (start_q),
        .order_o    (order_q)
    );

    burst_beat_ctr #(
        .BEAT_W(BEAT_W)
    ) i_beat_ctr (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .load_i(load_i),
        .step_i(step_w),
        .cnt_o (cnt_q)
    );

    burst_order_map #(
        .BEAT_W(BEAT_W)
    ) i_order_map (
        .start_i(start_q[BEAT_W-1:0]),
        .cnt_i  (cnt_q),
        .order_i(order_q),
        .low_o  (low_w)
    );

    assign addr_o = {start_q[ADDR_W-1:BEAT_W], low_w};
    assign low_o  = low_w;

endmodule

// File: rtl/burst_addr_seq_chk.sv
// Checker bound to the sequencer top.
module burst_addr_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              load_i,
    input logic [ADDR_W-1:0] load_addr_i,
    input logic              adv_n_i,
    input logic              mode_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic [1:0]        low_o
);

    // Order as seen at the ports: remembered at each load.
    logic seen_mode_q;
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            seen_mode_q <= 1'b1;
        end else if (load_i) begin
            seen_mode_q <= mode_i;
        end
    end

    // R1: reset clears the address
    assert_reset_clear_R1: assert property (@(posedge clk_i)
        rst_i |=> addr_o == '0);

    // R2, R8: a load (even with advance) shows the load address next cycle
    assert_load_capture_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> addr_o == $past(load_addr_i));

    // R3: upper bits only change on load
    assert_upper_stable_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !load_i |=> $stable(addr_o[ADDR_W-1:2]));

    // R6: an advance always moves to a different low value
    assert_advance_moves_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && !adv_n_i) |=> low_o != $past(low_o));

    // R5: linear order steps by one modulo 4
    assert_linear_step_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && !adv_n_i && !seen_mode_q) |=> low_o == $past(low_o) + 2'd1);

    // R7: a hold freezes the address
    assert_hold_freeze_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && adv_n_i) |=> $stable(addr_o));

    // R10: low output matches the address slice
    always_comb begin
        if (!rst_i) begin
            assert_low_slice_R10: assert (low_o == addr_o[1:0]);
        end
    end

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .load_i     (load_i),
    .load_addr_i(load_addr_i),
    .adv_n_i    (adv_n_i),
    .mode_i     (mode_i),
    .addr_o     (addr_o),
    .low_o      (low_o)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;

    localparam int ADDR_W = 16;

    logic              clk_i = 1'b0;
    logic              rst_i = 1'b1;
    logic              load_i = 1'b0;
    logic [ADDR_W-1:0] load_addr_i = '0;
    logic              adv_n_i = 1'b1;
    logic              mode_i = 1'b1;
    logic [ADDR_W-1:0] addr_o;
    logic [1:0]        low_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Bench model of the captured state.
    logic [ADDR_W-3:0] m_upper = '0;
    logic [1:0]        m_start = 2'd0;
    logic              m_mode = 1'b1;
    int                m_beat = 0;

    always #5 clk_i = ~clk_i;

    burst_addr_seq #(.ADDR_W(ADDR_W)) i_burst_addr_seq (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (load_i),
        .load_addr_i(load_addr_i),
        .adv_n_i    (adv_n_i),
        .mode_i     (mode_i),
        .addr_o     (addr_o),
        .low_o      (low_o)
    );

    function automatic logic [1:0] exp_low(logic [1:0] s, int k, logic m);
        logic [1:0] kk;
        kk = 2'(k % 4);
        return m ? (s ^ kk) : 2'(s + kk);
    endfunction

    task automatic check(string req, logic [ADDR_W-1:0] exp);
        checks++;
        if (addr_o !== exp || low_o !== exp[1:0]) begin
            failures++;
            $display("FAIL %s: addr=%h low=%b expected addr=%h low=%b",
                     req, addr_o, low_o, exp, exp[1:0]);
        end
    endtask

    // Drive at a negative edge, let one rising edge pass, update the model,
    // then compare at the following negative edge.
    task automatic step(string req, logic ld, logic [ADDR_W-1:0] a,
                        logic advn, logic md);
        load_i      = ld;
        load_addr_i = a;
        adv_n_i     = advn;
        mode_i      = md;
        @(negedge clk_i);
        if (rst_i) begin
            m_upper = '0; m_start = 2'd0; m_mode = 1'b1; m_beat = 0;
        end else if (ld) begin
            m_upper = a[ADDR_W-1:2]; m_start = a[1:0]; m_mode = md; m_beat = 0;
        end else if (!advn) begin
            m_beat = (m_beat + 1) % 4;
        end
        check(req, {m_upper, exp_low(m_start, m_beat, m_mode)});
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] a;
        @(negedge clk_i);
        step("R1", 1'b0, '0, 1'b0, 1'b0);
        rst_i = 1'b0;
        // R1: after reset, advance in interleaved order from 00
        step("R1", 1'b0, '0, 1'b0, 1'b0);
        step("R1", 1'b0, '0, 1'b0, 1'b0);

        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                a = {14'(16'h2A5 * (s + 1) + m * 16'h1111), 2'(s)};
                step("R2", 1'b1, a, 1'b1, 1'(m));
                for (int k = 1; k <= 6; k++) begin
                    // R4 interleaved, R5 linear; beats past the fourth wrap (R6)
                    step(k > 4 ? "R6" : (m == 1 ? "R4" : "R5"),
                         1'b0, '1, 1'b0, 1'(m));
                    if (k == 2) begin
                        step("R7", 1'b0, '0, 1'b1, 1'(m));
                        step("R7", 1'b0, '1, 1'b1, 1'(m));
                    end
                end
                // R9: mode_i flipped mid-burst changes nothing
                step("R9", 1'b0, '0, 1'b0, 1'(~m));
                step("R9", 1'b0, '0, 1'b0, 1'(~m));
                step("R3", 1'b0, ~a, 1'b1, 1'(~m));
                // R8: load with advance in the same cycle restarts at beat 0
                step("R8", 1'b1, a ^ 16'h5A5C, 1'b0, 1'(m));
                step("R6", 1'b0, '0, 1'b0, 1'(m));
            end
        end

        // R1: reset in the middle of a burst
        rst_i = 1'b1;
        step("R1", 1'b0, '0, 1'b0, 1'b0);
        rst_i = 1'b0;
        step("R1", 1'b1, 16'hBEEF, 1'b1, 1'b0);
        step("R5", 1'b0, '0, 1'b0, 1'b0);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule